// File: doc/BRIEF.md
# Trap Return Status Update Unit

This block carries out the two privileged return operations, the return from supervisor mode and the return from machine mode, against a small model of the hart's status state. That state is the current privilege level, the virtualization flag, the machine status bits (both interrupt enables and their saved copies, both saved-privilege fields, the modify-privilege bit, the saved virtualization bit and the trap-supervisor-return gate), the hypervisor status bits (the supervisor saved-virtualization bit and the virtual trap-supervisor-return gate), and the two exception return addresses.

A load port writes the whole model in one cycle. A return request is then evaluated against the current state and the configuration inputs. The inputs are compressed-instruction support, hypervisor extension present, privileged version 1.12 or later, and memory protection implemented with zero rules. One cycle after the request the block reports one of two results. The first is a trap with its cause code, with the state left unchanged. The second is a completed return, with the state updated, the return address driven out and, where virtualization is restored to on, a one-cycle register-bank swap pulse.

Top module: `trap_ret_unit`

## Requirements
- R1: After reset the privilege is M (3), the virtualization flag is 0, every status bit and both return addresses are 0, and done and bank_swap are 0.
- R2: A supervisor return requested at privilege U (0) traps with the illegal-instruction cause 2 and changes no state.
- R3: When compressed support is off and bits [1:0] of the selected return address are nonzero, a return traps with the misaligned cause 0. The privilege check is made first. With compressed support on, these address bits never cause a trap.
- R4: A supervisor return that passes the R2 and R3 checks traps with cause 2 when the trap-supervisor-return gate is set and the privilege is not M. If that gate does not trap, it traps with the virtual-instruction cause 22 when virtualization is on and the virtual gate is set.
- R5: A supervisor return that completes copies the saved supervisor enable into the supervisor enable, sets the saved supervisor enable to 1, clears the supervisor saved privilege, and moves the privilege to S (1) if that saved bit was 1 and to U otherwise.
- R6: When the hypervisor extension is present and virtualization is off, a completed supervisor return sets virtualization to the old supervisor saved-virtualization bit and clears that bit. The bank swap pulses when the old value was 1. Otherwise virtualization is unchanged.
- R7: A machine return requested below M traps with cause 2. When memory protection has zero rules and the machine saved privilege is not M, a machine return that passes the R3 check traps with the access-fault cause 1.
- R8: A machine return that completes copies the saved machine enable into the machine enable, sets the saved machine enable to 1, sets the machine saved privilege to U, clears the saved virtualization bit and moves the privilege to the old machine saved privilege. When the hypervisor extension is present, virtualization takes the old saved virtualization bit, and the bank swap pulses when that bit was 1.
- R9: With version 1.12 or later, the modify-privilege bit is cleared by every completed supervisor return. It is cleared by a completed machine return only when the target privilege is not M. Without version 1.12 it is never changed by a return.
- R10: Results appear in the cycle after the request: done is high for one cycle, trap and cause are valid, and ret_pc is the selected return address on completion and 0 on a trap. bank_swap is high for at most that one cycle.
- R11: A load in the same cycle as a return request takes effect and the request is dropped. A loaded privilege or machine saved-privilege value of 2 is stored as U. Status vector layout: bit 0 supervisor enable, 1 machine enable, 2 saved supervisor enable, 3 saved machine enable, 4 supervisor saved privilege, 6:5 machine saved privilege, 7 modify-privilege, 8 saved virtualization, 9 trap-supervisor-return gate, 10 supervisor saved-virtualization, 11 virtual trap-supervisor-return gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_rvc_i | input | 1 | Compressed instructions supported |
| cfg_rvh_i | input | 1 | Hypervisor extension present |
| cfg_v112_i | input | 1 | Privileged version 1.12 or later |
| pmp_lockout_i | input | 1 | Memory protection implemented with zero rules |
| ld_en_i | input | 1 | Load the state model |
| ld_priv_i | input | 2 | Privilege to load |
| ld_virt_i | input | 1 | Virtualization flag to load |
| ld_stat_i | input | 12 | Status vector to load (layout in R11) |
| ld_sepc_i | input | XLEN | Supervisor return address to load |
| ld_mepc_i | input | XLEN | Machine return address to load |
| ret_req_i | input | 1 | Return request |
| ret_mret_i | input | 1 | 1 = machine return, 0 = supervisor return |
| done_o | output | 1 | Result valid, one cycle after the request |
| trap_o | output | 1 | The return trapped |
| cause_o | output | 5 | Trap cause (0, 1, 2, 22), 0 on completion |
| ret_pc_o | output | XLEN | Return address on completion, 0 on a trap |
| bank_swap_o | output | 1 | One-cycle hypervisor register bank swap pulse |
| priv_o | output | 2 | Current privilege |
| virt_o | output | 1 | Current virtualization flag |
| stat_o | output | 12 | Current status vector |

## Verification
A corrupted status bit shows up on stat_o in the very next cycle. It also shapes the next return, either as a wrong trap cause or as a wrong privilege and virtualization one cycle after that request. Because every gate and field copy depends on the loaded state, the sweep loads each combination of gates, saved fields, privilege and configuration, issues one return, and compares the full result and the full state on the cycle after it. A wrong gate priority or a missing clear therefore appears within two cycles of the load.

// File: rtl/trap_ret_pkg.sv
package trap_ret_pkg;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [4:0] CAUSE_MISALIGN = 5'd0;
  localparam logic [4:0] CAUSE_ACCESS   = 5'd1;
  localparam logic [4:0] CAUSE_ILLEGAL  = 5'd2;
  localparam logic [4:0] CAUSE_VIRT     = 5'd22;

  // MSB first; bit 0 is sie
  typedef struct packed {
    logic       vtsr;
    logic       spv;
    logic       tsr;
    logic       mpv;
    logic       mprv;
    logic [1:0] mpp;
    logic       spp;
    logic       mpie;
    logic       spie;
    logic       mie;
    logic       sie;
  } stat_t;

  localparam int STAT_W = $bits(stat_t);

  typedef struct packed {
    logic       trap;
    logic [4:0] cause;
    stat_t      st;
    logic [1:0] priv;
    logic       virt;
    logic       swap;
  } ret_res_t;

endpackage

// File: rtl/trap_ret_sret.sv
module trap_ret_sret
  import trap_ret_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  stat_t      st_i,
  input  logic [1:0] epc_lo_i,
  input  logic       rvc_i,
  input  logic       rvh_i,
  input  logic       v112_i,
  output ret_res_t   res_o
);

  always_comb begin
    res_o      = '0;
    res_o.st   = st_i;
    res_o.priv = priv_i;
    res_o.virt = virt_i;
    if (priv_i < PRIV_S) begin
      res_o.trap  = 1'b1;
      res_o.cause = CAUSE_ILLEGAL;
    end else if (!rvc_i && (epc_lo_i != 2'b00)) begin
      res_o.trap  = 1'b1;
      res_o.cause = CAUSE_MISALIGN;
    end else if (st_i.tsr && (priv_i != PRIV_M)) begin
      res_o.trap  = 1'b1;
      res_o.cause = CAUSE_ILLEGAL;
    end else if (virt_i && st_i.vtsr) begin
      res_o.trap  = 1'b1;
      res_o.cause = CAUSE_VIRT;
    end else begin
      res_o.st.sie  = st_i.spie;
      res_o.st.spie = 1'b1;
      res_o.st.spp  = 1'b0;
      if (v112_i) res_o.st.mprv = 1'b0;
      res_o.priv = st_i.spp ? PRIV_S : PRIV_U;
      if (rvh_i && !virt_i) begin
        res_o.st.spv = 1'b0;
        res_o.virt   = st_i.spv;
        res_o.swap   = st_i.spv;
      end
    end
  end

endmodule

// File: rtl/trap_ret_mret.sv
module trap_ret_mret
  import trap_ret_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  stat_t      st_i,
  input  logic [1:0] epc_lo_i,
  input  logic       rvc_i,
  input  logic       rvh_i,
  input  logic       v112_i,
  input  logic       pmp_lockout_i,
  output ret_res_t   res_o
);

  always_comb begin
    res_o      = '0;
    res_o.st   = st_i;
    res_o.priv = priv_i;
    res_o.virt = virt_i;
    if (priv_i != PRIV_M) begin
      res_o.trap  = 1'b1;
      res_o.cause = CAUSE_ILLEGAL;
    end else if (!rvc_i && (epc_lo_i != 2'b00)) begin
      res_o.trap  = 1'b1;
      res_o.cause = CAUSE_MISALIGN;
    end else if (pmp_lockout_i && (st_i.mpp != PRIV_M)) begin
      res_o.trap  = 1'b1;
      res_o.cause = CAUSE_ACCESS;
    end else begin
      res_o.st.mie  = st_i.mpie;
      res_o.st.mpie = 1'b1;
      res_o.st.mpp  = PRIV_U;
      res_o.st.mpv  = 1'b0;
      if (v112_i && (st_i.mpp != PRIV_M)) res_o.st.mprv = 1'b0;
      res_o.priv = st_i.mpp;
      if (rvh_i) begin
        res_o.virt = st_i.mpv;
        res_o.swap = st_i.mpv;
      end
    end
  end

endmodule

// File: rtl/trap_ret_unit.sv
module trap_ret_unit
  import trap_ret_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_rvc_i,
  input  logic              cfg_rvh_i,
  input  logic              cfg_v112_i,
  input  logic              pmp_lockout_i,
  input  logic              ld_en_i,
  input  logic [1:0]        ld_priv_i,
  input  logic              ld_virt_i,
  input  logic [STAT_W-1:0] ld_stat_i,
  input  logic [XLEN-1:0]   ld_sepc_i,
  input  logic [XLEN-1:0]   ld_mepc_i,
  input  logic              ret_req_i,
  input  logic              ret_mret_i,
  output logic              done_o,
  output logic              trap_o,
  output logic [4:0]        cause_o,
  output logic [XLEN-1:0]   ret_pc_o,
  output logic              bank_swap_o,
  output logic [1:0]        priv_o,
  output logic              virt_o,
  output logic [STAT_W-1:0] stat_o
);

  // reset synchronizer: assert async, release on clock
  logic [1:0] rsync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= 2'b00;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  // state model
  logic [1:0]      priv_q, priv_d;
  logic            virt_q, virt_d;
  stat_t           st_q, st_d;
  logic [XLEN-1:0] sepc_q, sepc_d, mepc_q, mepc_d;
  logic            st_en;

  // result registers
  logic            done_q, done_d, trap_q, trap_d, swap_q, swap_d, mret_q, mret_d;
  logic [4:0]      cause_q, cause_d;
  logic [XLEN-1:0] pc_q, pc_d;

  ret_res_t s_res, m_res, sel_res;

  trap_ret_sret u_sret (
    .priv_i   (priv_q),
    .virt_i   (virt_q),
    .st_i     (st_q),
    .epc_lo_i (sepc_q[1:0]),
    .rvc_i    (cfg_rvc_i),
    .rvh_i    (cfg_rvh_i),
    .v112_i   (cfg_v112_i),
    .res_o    (s_res)
  );

  trap_ret_mret u_mret (
    .priv_i        (priv_q),
    .virt_i        (virt_q),
    .st_i          (st_q),
    .epc_lo_i      (mepc_q[1:0]),
    .rvc_i         (cfg_rvc_i),
    .rvh_i         (cfg_rvh_i),
    .v112_i        (cfg_v112_i),
    .pmp_lockout_i (pmp_lockout_i),
    .res_o         (m_res)
  );

  assign sel_res = ret_mret_i ? m_res : s_res;

  // next-state logic
  always_comb begin
    priv_d  = priv_q;
    virt_d  = virt_q;
    st_d    = st_q;
    sepc_d  = sepc_q;
    mepc_d  = mepc_q;
    st_en   = 1'b0;
    done_d  = 1'b0;
    trap_d  = 1'b0;
    cause_d = '0;
    pc_d    = '0;
    swap_d  = 1'b0;
    mret_d  = mret_q;
    if (ld_en_i) begin
      st_en  = 1'b1;
      priv_d = (ld_priv_i == 2'd2) ? PRIV_U : ld_priv_i;
      st_d   = stat_t'(ld_stat_i);
      if (st_d.mpp == 2'd2) st_d.mpp = PRIV_U;
      virt_d = ld_virt_i;
      sepc_d = ld_sepc_i;
      mepc_d = ld_mepc_i;
    end else if (ret_req_i) begin
      done_d  = 1'b1;
      mret_d  = ret_mret_i;
      trap_d  = sel_res.trap;
      cause_d = sel_res.cause;
      if (!sel_res.trap) begin
        st_en  = 1'b1;
        st_d   = sel_res.st;
        priv_d = sel_res.priv;
        virt_d = sel_res.virt;
        swap_d = sel_res.swap;
        pc_d   = ret_mret_i ? mepc_q : sepc_q;
      end
    end
  end

  // state registers with explicit enable
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      priv_q <= PRIV_M;
      virt_q <= 1'b0;
      st_q   <= '0;
      sepc_q <= '0;
      mepc_q <= '0;
    end else if (st_en) begin
      priv_q <= priv_d;
      virt_q <= virt_d;
      st_q   <= st_d;
      sepc_q <= sepc_d;
      mepc_q <= mepc_d;
    end
  end

  // result registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      cause_q <= '0;
      pc_q    <= '0;
      swap_q  <= 1'b0;
      mret_q  <= 1'b0;
    end else begin
      done_q  <= done_d;
      trap_q  <= trap_d;
      cause_q <= cause_d;
      pc_q    <= pc_d;
      swap_q  <= swap_d;
      mret_q  <= mret_d;
    end
  end

  assign done_o      = done_q;
  assign trap_o      = trap_q;
  assign cause_o     = cause_q;
  assign ret_pc_o    = pc_q;
  assign bank_swap_o = swap_q;
  assign priv_o      = priv_q;
  assign virt_o      = virt_q;
  assign stat_o      = st_q;

  // a trap leaves the whole model untouched
  p_trap_holds_state_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_q && trap_q) |-> (priv_q == $past(priv_q) && virt_q == $past(virt_q) && st_q == $past(st_q)));

  p_cause_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    trap_q |-> (cause_q == CAUSE_MISALIGN || cause_q == CAUSE_ACCESS ||
                cause_q == CAUSE_ILLEGAL || cause_q == CAUSE_VIRT));

  p_sret_fields_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_q && !trap_q && !mret_q) |-> (st_q.spie && !st_q.spp && priv_q != PRIV_M));

  p_swap_turns_virt_on_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    bank_swap_o |-> virt_q);

  p_mret_from_m_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_q && !trap_q && mret_q) |-> ($past(priv_q) == PRIV_M));

  p_mret_fields_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_q && !trap_q && mret_q) |-> (st_q.mpp == PRIV_U && st_q.mpie && !st_q.mpv));

  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_q |=> !done_q || $past(ret_req_i));

  p_no_reserved_priv_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (priv_q != 2'd2) && (st_q.mpp != 2'd2));

endmodule

// File: tb/tb_trap_ret_unit.sv
module tb_trap_ret_unit;
  import trap_ret_pkg::*;

  localparam int XLEN = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              cfg_rvc_i, cfg_rvh_i, cfg_v112_i, pmp_lockout_i;
  logic              ld_en_i, ld_virt_i, ret_req_i, ret_mret_i;
  logic [1:0]        ld_priv_i;
  logic [11:0]       ld_stat_i;
  logic [XLEN-1:0]   ld_sepc_i, ld_mepc_i;
  logic              done_o, trap_o, bank_swap_o, virt_o;
  logic [4:0]        cause_o;
  logic [XLEN-1:0]   ret_pc_o;
  logic [1:0]        priv_o;
  logic [11:0]       stat_o;

  int n_chk = 0;
  int n_fail = 0;

  trap_ret_unit #(.XLEN(XLEN)) dut (.*);

  always #4 clk_i = ~clk_i;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // expected {trap, cause, pc, swap, priv, virt, stat}
  function automatic logic [53:0] model(bit m, bit [1:0] pr, bit vt, bit [11:0] st,
                                        bit [31:0] sepc, bit [31:0] mepc,
                                        bit rvc, bit rvh, bit v112, bit pmpz);
    int        cause = -1;
    bit [31:0] epc = m ? mepc : sepc;
    bit [11:0] ns = st;
    bit [1:0]  npr;
    bit        nv = vt, sw = 1'b0;
    if (!m) begin
      if (pr == 2'd0) cause = 2;
      else if (!rvc && (epc % 4) != 0) cause = 0;
      else if (st[9] && pr != 2'd3) cause = 2;
      else if (vt && st[11]) cause = 22;
    end else begin
      if (pr != 2'd3) cause = 2;
      else if (!rvc && (epc % 4) != 0) cause = 0;
      else if (pmpz && st[6:5] != 2'd3) cause = 1;
    end
    if (cause >= 0) return {1'b1, cause[4:0], 32'h0, 1'b0, pr, vt, st};
    if (!m) begin
      ns[0] = st[2]; ns[2] = 1'b1; ns[4] = 1'b0;
      if (v112) ns[7] = 1'b0;
      npr = st[4] ? 2'd1 : 2'd0;
      if (rvh && !vt) begin nv = st[10]; sw = st[10]; ns[10] = 1'b0; end
    end else begin
      ns[1] = st[3]; ns[3] = 1'b1; ns[6:5] = 2'd0; ns[8] = 1'b0;
      if (v112 && st[6:5] != 2'd3) ns[7] = 1'b0;
      npr = st[6:5];
      if (rvh) begin nv = st[8]; sw = st[8]; end
    end
    return {1'b0, 5'd0, epc, sw, npr, nv, ns};
  endfunction

  function automatic string tag_of(bit m, bit [1:0] pr, logic [53:0] e);
    if (e[53]) begin
      case (e[52:48])
        5'd0:    return "R3";
        5'd1:    return "R7";
        5'd22:   return "R4";
        default: return m ? "R7" : (pr == 2'd0 ? "R2" : "R4");
      endcase
    end
    return m ? "R8/R9" : "R5/R6/R9";
  endfunction

  // called at a falling edge: load, request, then compare
  task automatic run_op(bit m, bit [1:0] pr, bit vt, bit [11:0] st, bit [31:0] sepc,
                        bit [31:0] mepc, bit rvc, bit rvh, bit v112, bit pmpz);
    logic [53:0] e;
    cfg_rvc_i = rvc; cfg_rvh_i = rvh; cfg_v112_i = v112; pmp_lockout_i = pmpz;
    ld_en_i = 1'b1; ld_priv_i = pr; ld_virt_i = vt; ld_stat_i = st;
    ld_sepc_i = sepc; ld_mepc_i = mepc; ret_req_i = 1'b0;
    @(negedge clk_i);
    ld_en_i = 1'b0; ret_req_i = 1'b1; ret_mret_i = m;
    @(negedge clk_i);
    ret_req_i = 1'b0;
    e = model(m, pr, vt, st, sepc, mepc, rvc, rvh, v112, pmpz);
    check({tag_of(m, pr, e), " R10"},
          {10'd0, trap_o, cause_o, ret_pc_o, bank_swap_o, priv_o, virt_o, stat_o},
          {10'd0, e});
    if (!done_o) begin
      n_fail++;
      $display("FAIL R10 done act=0 exp=1");
    end
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit [1:0] plist [3] = '{2'd0, 2'd1, 2'd3};
    rst_ni = 1'b0;
    cfg_rvc_i = 0; cfg_rvh_i = 0; cfg_v112_i = 0; pmp_lockout_i = 0;
    ld_en_i = 0; ld_virt_i = 0; ret_req_i = 0; ret_mret_i = 0;
    ld_priv_i = 0; ld_stat_i = 0; ld_sepc_i = 0; ld_mepc_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R1 reset state
    check("R1 state", {priv_o, virt_o, stat_o, done_o, bank_swap_o},
          {2'd3, 1'b0, 12'h000, 1'b0, 1'b0});

    // R11 reserved values coerced on load
    ld_en_i = 1; ld_priv_i = 2'd2; ld_virt_i = 0; ld_stat_i = 12'h040 | 12'h001;
    @(negedge clk_i);
    ld_en_i = 0;
    check("R11 coerce", {priv_o, stat_o}, {2'd0, 12'h001});

    // R11 load beats a simultaneous request
    ld_en_i = 1; ld_priv_i = 2'd3; ld_stat_i = 12'h068; ret_req_i = 1; ret_mret_i = 1;
    ld_mepc_i = 32'h100;
    @(negedge clk_i);
    ld_en_i = 0; ret_req_i = 0;
    check("R11 load wins", {done_o, priv_o, stat_o}, {1'b0, 2'd3, 12'h068});

    // R6 directed: virtualization restored from saved bit, swap pulse
    run_op(1'b0, 2'd1, 1'b0, 12'h410, 32'h200, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R6 virt on", {virt_o, bank_swap_o, priv_o}, {1'b1, 1'b1, 2'd1});
    @(negedge clk_i);
    check("R10 swap single", {done_o, bank_swap_o}, {1'b0, 1'b0});

    // R9 directed: machine return to M keeps modify-privilege
    run_op(1'b1, 2'd3, 1'b0, 12'h0E0, 32'h0, 32'h300, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R9 mprv kept", {stat_o[7], priv_o}, {1'b1, 2'd3});

    // R3 directed: compressed support hides misalignment
    run_op(1'b1, 2'd3, 1'b0, 12'h060, 32'h0, 32'h302, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R3 rvc no trap", {trap_o, ret_pc_o}, {1'b0, 32'h302});

    // near-exhaustive sweep
    for (int op = 0; op < 2; op++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int mi = 0; mi < (op == 1 ? 3 : 1); mi++) begin
          for (int b = 0; b < 4096; b++) begin
            bit [11:0] bb = b[11:0];
            bit [11:0] st;
            bit [1:0]  mpp = (op == 1) ? plist[mi] : plist[(b >> 2) % 3];
            bit [31:0] off = bb[11] ? 32'(pi + 1) : 32'd0;
            st[0]   = bb[1] ^ bb[5];
            st[1]   = bb[0] ^ bb[4];
            st[2]   = bb[3] ^ bb[7];
            st[3]   = bb[2] ^ bb[6];
            st[4]   = bb[5];
            st[6:5] = mpp;
            st[7]   = bb[10];
            st[8]   = bb[9];
            st[9]   = bb[6];
            st[10]  = bb[8];
            st[11]  = bb[7];
            run_op(op[0], plist[pi], bb[4], st, 32'h4000 + off, 32'h8000 + off,
                   bb[0], bb[1], bb[2], bb[3]);
          end
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule